// File: doc/BRIEF.md
# Thermal monitor controller

This block is the digital controller for a temperature-sensing ADC with several sensor channels. In automatic mode a sequencer waits out a programmable interval and then converts every enabled channel in ascending order, one conversion per channel. It stores each 12-bit result and compares it against two per-channel thresholds, one for an alarm and one for shutdown. The sensor code falls as temperature rises, so a sample counts as hot when its code is at or below a threshold. Each comparison passes through a consecutive-sample debounce counter before it raises an interrupt-pending bit or latches a shutdown. While any enabled channel's last sample is hot, a shorter second interval replaces the normal one.

Software reaches the block through a simple word-addressed read/write port. A latched shutdown can be steered per channel to a reset-controller output, a GPIO output, or both, and one polarity bit sets the active level of both outputs. With automatic mode off, a user register drives the ADC start and channel-select lines directly, and each finished conversion is still stored. Channel 0 is reserved: it cannot be enabled for polling.

Top module: `thermo_mon`

## Requirements
- R1: After reset all data registers and the pending register read 0, `irq` is 0, `adc_start` is 0, and both shutdown outputs sit at their inactive level for polarity 0, which is 1.
- R2: While bit 0 of the auto-control register (0x04) is 0, `adc_start` follows bit 0 of the user register (0x00) and `adc_chan` follows bits [5:4] of it. A conversion that finishes while `adc_start` is high is stored in that channel's data register.
- R3: With automatic mode on, the enabled channels are converted in ascending order. `adc_start` is held high and `adc_chan` is held stable until `adc_done`. After the last conversion of a scan, `adc_start` stays low for exactly P+1 cycles, where P is the active period.
- R4: P is the normal period register (0x68) unless the last sample of some enabled channel was at or below its alarm or shutdown compare value. In that case P is the high-temperature period register (0x6C).
- R5: A sample is over a threshold when code <= compare value. A code of compare+1 is not over.
- R6: Pending bit ch (0x0C) is set by the sample that completes N consecutive samples at or below the alarm compare value (0x30+4·ch), where N is the alarm debounce register (0x60). N=0 acts like 1. A sample that is not over restarts the count.
- R7: Writing 1 to pending bit ch clears it, and a bit set by a sample in the same cycle wins. `irq` is the OR of the pending bits ANDed with the interrupt enables in bits [2:0] of 0x08.
- R8: A channel's shutdown latches on the sample that completes M consecutive samples at or below its shutdown compare value (0x40+4·ch), where M is the shutdown debounce register (0x64). It stays latched until reset, even after cooling.
- R9: `shut_gpio` is active when a latched channel has its bit 4+ch set in 0x08. `shut_rst` is active when a latched channel has its bit 8+ch set. Bit 8 of 0x04 selects active-high (1) or active-low (0), and the inactive level is the opposite.
- R10: Channel 0 is reserved. Bit 4 of 0x04 ignores writes and reads 0, and channel 0 is never converted in automatic mode. Bits 5 and 6 enable channels 1 and 2.
- R11: A data register (0x20+4·ch) reads 0 until that channel's first conversion completes, and after that it reads the latest 12-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| adc_start | output | 1 | Conversion request, held until done |
| adc_chan | output | 2 | Channel to convert |
| adc_done | input | 1 | One-cycle conversion-complete pulse |
| adc_code | input | 12 | Conversion result, valid with `adc_done` |
| irq | output | 1 | Alarm interrupt |
| shut_rst | output | 1 | Shutdown toward the reset controller |
| shut_gpio | output | 1 | Shutdown toward a GPIO pin |

## Verification
The hardest state to reach from the ports is a debounce run that is broken just before it completes. A run of this kind must produce no pending bit, so it is visible only as an absence. The bench's ADC model can alternate one channel's code between a value exactly at the compare threshold and a value above it on every conversion. This holds the count below the debounce length indefinitely while the scan timing keeps running. A reference model updated at every completed conversion is compared with `irq` and both shutdown outputs on every clock. Directed reads then pin down the compare boundary, the latch after cooling, and the switch between the two periods, which is measured as the low time of `adc_start`.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    typedef enum logic {
        SQ_WAIT = 1'b0,
        SQ_CONV = 1'b1
    } seq_state_e;

    localparam int A_USER  = 'h00;
    localparam int A_AUTO  = 'h04;
    localparam int A_ENAB  = 'h08;
    localparam int A_PEND  = 'h0C;
    localparam int A_DATA  = 'h20;
    localparam int A_ACMP  = 'h30;
    localparam int A_SCMP  = 'h40;
    localparam int A_ADEB  = 'h60;
    localparam int A_SDEB  = 'h64;
    localparam int A_PNORM = 'h68;
    localparam int A_PHOT  = 'h6C;

    localparam int SRC_LSB  = 4;
    localparam int POL_BIT  = 8;
    localparam int GPIO_LSB = 4;
    localparam int RST_LSB  = 8;

endpackage

// File: rtl/thermo_chan.sv
module thermo_chan #(
    parameter int CW  = 12,
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [CW-1:0]  smp_code,
    input  logic [CW-1:0]  alm_cmp,
    input  logic [CW-1:0]  sht_cmp,
    input  logic [DBW-1:0] alm_deb,
    input  logic [DBW-1:0] sht_deb,
    output logic           alm_hit,
    output logic           sht_latch,
    output logic           hot
);

    typedef struct packed {
        logic [DBW-1:0] acnt;
        logic [DBW-1:0] scnt;
        logic           latch;
        logic           hot;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic alm_over, sht_over;
    logic [DBW-1:0] acnt_nx, scnt_nx;

    always_comb begin
        st_d     = st_q;
        alm_hit  = 1'b0;
        alm_over = (smp_code <= alm_cmp);
        sht_over = (smp_code <= sht_cmp);
        acnt_nx  = alm_over ? ((st_q.acnt == '1) ? st_q.acnt : st_q.acnt + 1'b1) : '0;
        scnt_nx  = sht_over ? ((st_q.scnt == '1) ? st_q.scnt : st_q.scnt + 1'b1) : '0;
        if (smp_vld) begin
            st_d.acnt = acnt_nx;
            st_d.scnt = scnt_nx;
            st_d.hot  = alm_over | sht_over;
            alm_hit   = alm_over && (acnt_nx >= alm_deb);
            if (sht_over && (scnt_nx >= sht_deb)) begin
                st_d.latch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sht_latch = st_q.latch;
    assign hot       = st_q.hot;

    // R8: a latched shutdown never releases before reset
    assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.latch |=> st_q.latch);

    // R6: a sample above the alarm threshold restarts the run
    assert_run_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (smp_code > alm_cmp)) |=> (st_q.acnt == '0));

endmodule

// File: rtl/thermo_seq.sv
module thermo_seq
    import thermo_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int CHW  = 2,
    parameter int PW   = 16,
    parameter int RSVD = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           auto_en,
    input  logic [NCH-1:0] src_en,
    input  logic           hot,
    input  logic [PW-1:0]  per_norm,
    input  logic [PW-1:0]  per_hot,
    input  logic           usr_start,
    input  logic [CHW-1:0] usr_chan,
    input  logic           adc_done,
    output logic           adc_start,
    output logic [CHW-1:0] adc_chan,
    output logic           smp_vld,
    output logic [CHW-1:0] smp_chan
);

    typedef struct packed {
        seq_state_e     st;
        logic [PW-1:0]  cnt;
        logic [CHW-1:0] cur;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic [PW-1:0]  per_sel;
    logic [CHW-1:0] first_ch, next_ch;
    logic           first_ok, next_ok;

    always_comb begin
        first_ok = 1'b0;
        first_ch = '0;
        next_ok  = 1'b0;
        next_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (src_en[i]) begin
                first_ok = 1'b1;
                first_ch = CHW'(i);
                if (i > int'(st_q.cur)) begin
                    next_ok = 1'b1;
                    next_ch = CHW'(i);
                end
            end
        end
    end

    assign per_sel = hot ? per_hot : per_norm;

    always_comb begin
        st_d    = st_q;
        smp_vld = 1'b0;
        if (!auto_en) begin
            st_d.st  = SQ_WAIT;
            st_d.cnt = '0;
        end else begin
            case (st_q.st)
                SQ_WAIT: begin
                    if (st_q.cnt >= per_sel) begin
                        st_d.cnt = '0;
                        if (first_ok) begin
                            st_d.st  = SQ_CONV;
                            st_d.cur = first_ch;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                SQ_CONV: begin
                    if (adc_done) begin
                        smp_vld = 1'b1;
                        if (next_ok) begin
                            st_d.cur = next_ch;
                        end else begin
                            st_d.st  = SQ_WAIT;
                            st_d.cnt = '0;
                        end
                    end
                end
                default: st_d.st = SQ_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: SQ_WAIT, cnt: '0, cur: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign adc_start = auto_en ? (st_q.st == SQ_CONV) : usr_start;
    assign adc_chan  = auto_en ? st_q.cur : usr_chan;
    assign smp_chan  = st_q.cur;

    // R10: the reserved channel is never requested by the poller
    assert_no_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && adc_start) |-> (adc_chan != CHW'(RSVD)));

    // R3: request and channel hold until the conversion completes
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && adc_start && !adc_done) |=> (!auto_en || (adc_start && $stable(adc_chan))));

    // R3: within a scan the channel index only increases
    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && adc_start && adc_done) |=> (!auto_en || !adc_start || (adc_chan > $past(adc_chan))));

endmodule

// File: rtl/thermo_regs.sv
module thermo_regs
    import thermo_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int CHW  = 2,
    parameter int CW   = 12,
    parameter int DBW  = 8,
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int RSVD = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    st_vld,
    input  logic [CHW-1:0]          st_chan,
    input  logic [CW-1:0]           st_code,
    input  logic [NCH-1:0]          alm_hit,
    output logic                    usr_start,
    output logic [CHW-1:0]          usr_chan,
    output logic                    auto_en,
    output logic [NCH-1:0]          src_en,
    output logic                    shut_pol,
    output logic [NCH-1:0]          irq_en,
    output logic [NCH-1:0]          gpio_rt,
    output logic [NCH-1:0]          rst_rt,
    output logic [NCH-1:0]          pend,
    output logic [NCH-1:0][CW-1:0]  alm_cmp,
    output logic [NCH-1:0][CW-1:0]  sht_cmp,
    output logic [DBW-1:0]          alm_deb,
    output logic [DBW-1:0]          sht_deb,
    output logic [DW-1:0]           per_norm,
    output logic [DW-1:0]           per_hot
);

    typedef struct packed {
        logic                   ustart;
        logic [CHW-1:0]         uchan;
        logic                   auto_en;
        logic [NCH-1:0]         src;
        logic                   pol;
        logic [NCH-1:0]         irq_en;
        logic [NCH-1:0]         gpio;
        logic [NCH-1:0]         rst;
        logic [NCH-1:0]         pend;
        logic [NCH-1:0][CW-1:0] data;
        logic [NCH-1:0][CW-1:0] acmp;
        logic [NCH-1:0][CW-1:0] scmp;
        logic [DBW-1:0]         adeb;
        logic [DBW-1:0]         sdeb;
        logic [DW-1:0]          pnorm;
        logic [DW-1:0]          phot;
    } reg_st_t;

    reg_st_t st_q, st_d;
    logic [NCH-1:0] clr;

    function automatic logic hit_addr(input logic [AW-1:0] a, input int off);
        return a == AW'(off);
    endfunction

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_wr) begin
            if (hit_addr(bus_addr, A_USER)) begin
                st_d.ustart = bus_wdata[0];
                st_d.uchan  = bus_wdata[SRC_LSB +: CHW];
            end
            if (hit_addr(bus_addr, A_AUTO)) begin
                st_d.auto_en = bus_wdata[0];
                st_d.pol     = bus_wdata[POL_BIT];
                for (int i = 0; i < NCH; i++) begin
                    st_d.src[i] = (i == RSVD) ? 1'b0 : bus_wdata[SRC_LSB + i];
                end
            end
            if (hit_addr(bus_addr, A_ENAB)) begin
                st_d.irq_en = bus_wdata[0 +: NCH];
                st_d.gpio   = bus_wdata[GPIO_LSB +: NCH];
                st_d.rst    = bus_wdata[RST_LSB +: NCH];
            end
            if (hit_addr(bus_addr, A_PEND)) begin
                clr = bus_wdata[0 +: NCH];
            end
            for (int i = 0; i < NCH; i++) begin
                if (hit_addr(bus_addr, A_ACMP + 4 * i)) st_d.acmp[i] = bus_wdata[CW-1:0];
                if (hit_addr(bus_addr, A_SCMP + 4 * i)) st_d.scmp[i] = bus_wdata[CW-1:0];
            end
            if (hit_addr(bus_addr, A_ADEB))  st_d.adeb  = bus_wdata[DBW-1:0];
            if (hit_addr(bus_addr, A_SDEB))  st_d.sdeb  = bus_wdata[DBW-1:0];
            if (hit_addr(bus_addr, A_PNORM)) st_d.pnorm = bus_wdata;
            if (hit_addr(bus_addr, A_PHOT))  st_d.phot  = bus_wdata;
        end
        st_d.pend = (st_q.pend & ~clr) | alm_hit;
        for (int i = 0; i < NCH; i++) begin
            if (st_vld && (st_chan == CHW'(i))) begin
                st_d.data[i] = st_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_addr(bus_addr, A_USER)) begin
            bus_rdata[0]             = st_q.ustart;
            bus_rdata[SRC_LSB +: CHW] = st_q.uchan;
        end
        if (hit_addr(bus_addr, A_AUTO)) begin
            bus_rdata[0]              = st_q.auto_en;
            bus_rdata[SRC_LSB +: NCH] = st_q.src;
            bus_rdata[POL_BIT]        = st_q.pol;
        end
        if (hit_addr(bus_addr, A_ENAB)) begin
            bus_rdata[0 +: NCH]        = st_q.irq_en;
            bus_rdata[GPIO_LSB +: NCH] = st_q.gpio;
            bus_rdata[RST_LSB +: NCH]  = st_q.rst;
        end
        if (hit_addr(bus_addr, A_PEND)) bus_rdata[0 +: NCH] = st_q.pend;
        for (int i = 0; i < NCH; i++) begin
            if (hit_addr(bus_addr, A_DATA + 4 * i)) bus_rdata[CW-1:0] = st_q.data[i];
            if (hit_addr(bus_addr, A_ACMP + 4 * i)) bus_rdata[CW-1:0] = st_q.acmp[i];
            if (hit_addr(bus_addr, A_SCMP + 4 * i)) bus_rdata[CW-1:0] = st_q.scmp[i];
        end
        if (hit_addr(bus_addr, A_ADEB))  bus_rdata[DBW-1:0] = st_q.adeb;
        if (hit_addr(bus_addr, A_SDEB))  bus_rdata[DBW-1:0] = st_q.sdeb;
        if (hit_addr(bus_addr, A_PNORM)) bus_rdata = st_q.pnorm;
        if (hit_addr(bus_addr, A_PHOT))  bus_rdata = st_q.phot;
    end

    assign usr_start = st_q.ustart;
    assign usr_chan  = st_q.uchan;
    assign auto_en   = st_q.auto_en;
    assign src_en    = st_q.src;
    assign shut_pol  = st_q.pol;
    assign irq_en    = st_q.irq_en;
    assign gpio_rt   = st_q.gpio;
    assign rst_rt    = st_q.rst;
    assign pend      = st_q.pend;
    assign alm_cmp   = st_q.acmp;
    assign sht_cmp   = st_q.scmp;
    assign alm_deb   = st_q.adeb;
    assign sht_deb   = st_q.sdeb;
    assign per_norm  = st_q.pnorm;
    assign per_hot   = st_q.phot;

    // R7: a write-one clear empties the bits it names unless a new hit lands
    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_addr(bus_addr, A_PEND) && (alm_hit == '0))
        |=> ((st_q.pend & $past(bus_wdata[NCH-1:0])) == '0));

    // R11: stored codes change only on a completed conversion
    assert_data_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_vld |=> $stable(st_q.data));

endmodule

// File: rtl/thermo_mon.sv
module thermo_mon #(
    parameter int NCH  = 3,
    parameter int CHW  = 2,
    parameter int CW   = 12,
    parameter int DBW  = 8,
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int RSVD = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           adc_start,
    output logic [CHW-1:0] adc_chan,
    input  logic           adc_done,
    input  logic [CW-1:0]  adc_code,
    output logic           irq,
    output logic           shut_rst,
    output logic           shut_gpio
);

    logic                   usr_start, auto_en, shut_pol, hot_any;
    logic [CHW-1:0]         usr_chan, smp_chan;
    logic [NCH-1:0]         src_en, irq_en, gpio_rt, rst_rt, pend;
    logic [NCH-1:0]         alm_hit, sht_latch, hot;
    logic [NCH-1:0][CW-1:0] alm_cmp, sht_cmp;
    logic [DBW-1:0]         alm_deb, sht_deb;
    logic [DW-1:0]          per_norm, per_hot;
    logic                   smp_vld, st_vld;
    logic                   gpio_act, rst_act;

    thermo_regs #(
        .NCH(NCH), .CHW(CHW), .CW(CW), .DBW(DBW), .DW(DW), .AW(AW), .RSVD(RSVD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_vld(st_vld), .st_chan(adc_chan), .st_code(adc_code), .alm_hit(alm_hit),
        .usr_start(usr_start), .usr_chan(usr_chan), .auto_en(auto_en), .src_en(src_en),
        .shut_pol(shut_pol), .irq_en(irq_en), .gpio_rt(gpio_rt), .rst_rt(rst_rt),
        .pend(pend), .alm_cmp(alm_cmp), .sht_cmp(sht_cmp), .alm_deb(alm_deb),
        .sht_deb(sht_deb), .per_norm(per_norm), .per_hot(per_hot)
    );

    assign hot_any = |(hot & src_en);

    thermo_seq #(
        .NCH(NCH), .CHW(CHW), .PW(DW), .RSVD(RSVD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .src_en(src_en), .hot(hot_any),
        .per_norm(per_norm), .per_hot(per_hot), .usr_start(usr_start), .usr_chan(usr_chan),
        .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
        .smp_vld(smp_vld), .smp_chan(smp_chan)
    );

    assign st_vld = auto_en ? smp_vld : (adc_done && adc_start);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        thermo_chan #(.CW(CW), .DBW(DBW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .smp_vld(smp_vld && (smp_chan == CHW'(g))),
            .smp_code(adc_code), .alm_cmp(alm_cmp[g]), .sht_cmp(sht_cmp[g]),
            .alm_deb(alm_deb), .sht_deb(sht_deb),
            .alm_hit(alm_hit[g]), .sht_latch(sht_latch[g]), .hot(hot[g])
        );
    end

    assign irq       = |(pend & irq_en);
    assign gpio_act  = |(sht_latch & gpio_rt);
    assign rst_act   = |(sht_latch & rst_rt);
    assign shut_gpio = shut_pol ? gpio_act : ~gpio_act;
    assign shut_rst  = shut_pol ? rst_act : ~rst_act;

endmodule

// File: tb/thermo_mon_tb.sv
module thermo_mon_tb;
    localparam int CLK_NS = 10;
    localparam int LAT    = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        adc_start, adc_done = 1'b0;
    logic [1:0]  adc_chan;
    logic [11:0] adc_code = '0;
    logic        irq, shut_rst, shut_gpio;

    thermo_mon u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_start(adc_start),
        .adc_chan(adc_chan), .adc_done(adc_done), .adc_code(adc_code),
        .irq(irq), .shut_rst(shut_rst), .shut_gpio(shut_gpio)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit run = 0;
    // reference model state
    int m_data[3], m_acnt[3], m_scnt[3], m_acmp[3], m_scmp[3];
    int m_adeb = 0, m_sdeb = 0;
    bit [2:0] m_pend = '0, m_latch = '0, m_irqen = '0, m_gpio = '0, m_rst = '0;
    bit m_auto = 0, m_pol = 0, saw_rsvd = 0;
    // ADC stimulus
    int code_a[3], code_b[3];
    bit alt[3], phase[3];
    int chan_log[$];
    int low_run = 0, last_gap = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        @(posedge clk);
        #1;
        case (a)
            'h04: begin m_auto = d[0]; m_pol = d[8]; end
            'h08: begin m_irqen = d[2:0]; m_gpio = d[6:4]; m_rst = d[10:8]; end
            'h0C: m_pend &= ~d[2:0];
            'h60: m_adeb = d;
            'h64: m_sdeb = d;
            default: begin
                for (int i = 0; i < 3; i++) begin
                    if (a == 'h30 + 4 * i) m_acmp[i] = d;
                    if (a == 'h40 + 4 * i) m_scmp[i] = d;
                end
            end
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = 8'(a);
        #1 v = int'(bus_rdata);
    endtask

    task automatic model_sample(input int ch, input int cd, input bit a);
        if (ch < 3) m_data[ch] = cd;
        if (!a || ch >= 3) return;
        chan_log.push_back(ch);
        if (ch == 0) saw_rsvd = 1;
        m_acnt[ch] = (cd <= m_acmp[ch]) ? ((m_acnt[ch] < 255) ? m_acnt[ch] + 1 : 255) : 0;
        m_scnt[ch] = (cd <= m_scmp[ch]) ? ((m_scnt[ch] < 255) ? m_scnt[ch] + 1 : 255) : 0;
        if (cd <= m_acmp[ch] && m_acnt[ch] >= m_adeb) m_pend[ch] = 1'b1;
        if (cd <= m_scmp[ch] && m_scnt[ch] >= m_sdeb) m_latch[ch] = 1'b1;
    endtask

    // ADC model: fixed latency, aborts if the request drops
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                automatic int ch = int'(adc_chan);
                repeat (LAT) @(negedge clk);
                if (adc_start && int'(adc_chan) == ch) begin
                    automatic int cd = (ch < 3) ? ((alt[ch] && phase[ch]) ? code_b[ch] : code_a[ch]) : 0;
                    automatic bit snap = m_auto;
                    if (ch < 3) phase[ch] = ~phase[ch];
                    adc_code = 12'(cd);
                    adc_done = 1'b1;
                    @(posedge clk);
                    #2 model_sample(ch, cd, snap);
                    @(negedge clk);
                    adc_done = 1'b0;
                end
            end
        end
    end

    // per-clock comparison against the model (R6, R7, R8, R9)
    always @(negedge clk) begin
        if (run) begin
            automatic bit g = |(m_latch & m_gpio);
            automatic bit r = |(m_latch & m_rst);
            chk("R7 irq", int'(irq), int'(|(m_pend & m_irqen)));
            chk("R9 shut_gpio", int'(shut_gpio), int'(m_pol ? g : !g));
            chk("R9 shut_rst", int'(shut_rst), int'(m_pol ? r : !r));
        end
        if (!adc_start) low_run++;
        else begin
            if (low_run > 0) last_gap = low_run;
            low_run = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        for (int i = 0; i < 3; i++) begin
            m_data[i] = 0; m_acnt[i] = 0; m_scnt[i] = 0; m_acmp[i] = 0; m_scmp[i] = 0;
            code_a[i] = 3800; code_b[i] = 3800; alt[i] = 0; phase[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run = 1;
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            rd('h20 + 4 * i, v); chk("R1 data reset", v, 0);
        end
        rd('h0C, v); chk("R1 pend reset", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 adc_start", int'(adc_start), 0);
        chk("R1 shut_rst", int'(shut_rst), 1);
        chk("R1 shut_gpio", int'(shut_gpio), 1);

        // R2 user mode, R11 first conversion
        code_a[2] = 1445;
        wr('h00, (2 << 4) | 1);
        @(negedge clk);
        chk("R2 start follows user", int'(adc_start), 1);
        chk("R2 chan follows user", int'(adc_chan), 2);
        repeat (10) @(negedge clk);
        wr('h00, 0);
        repeat (6) @(negedge clk);
        chk("R2 start released", int'(adc_start), 0);
        rd('h28, v); chk("R11 data ch2 stored", v, 1445);
        rd('h24, v); chk("R11 data ch1 still zero", v, 0);

        // configuration
        wr('h34, 3500); wr('h38, 3500);
        wr('h44, 3400); wr('h48, 3400);
        wr('h60, 3); wr('h64, 2);
        wr('h68, 20); wr('h6C, 4);
        wr('h08, 'h006 | 'h040 | 'h200);
        code_a[1] = 3700; code_a[2] = 3650;
        wr('h04, 1 | (7 << 4));
        rd('h04, v); chk("R10 reserved source bit reads 0", v, 'h61);
        repeat (150) @(negedge clk);
        chk("R3 normal gap P+1", last_gap, 21);
        chk("R3 scans logged", int'(chan_log.size() >= 4), 1);
        foreach (chan_log[k]) chk("R3 ascending order", chan_log[k], (k % 2) ? 2 : 1);
        rd('h0C, v); chk("R6 no pending when cold", v, 0);

        // R6 broken runs: alternate at-threshold (R5 boundary) and cold
        code_b[1] = 3500; alt[1] = 1;
        repeat (250) @(negedge clk);
        rd('h0C, v); chk("R6 broken run never fires", v, 0);
        alt[1] = 0;
        // R5 compare+1 is not over
        code_a[1] = 3501;
        repeat (150) @(negedge clk);
        rd('h0C, v); chk("R5 code above compare ignored", v, 0);
        chk("R4 cold keeps normal period", last_gap, 21);
        code_a[1] = 3500;
        repeat (150) @(negedge clk);
        rd('h0C, v); chk("R6 pending after debounce", v, 2);
        chk("R6 irq raised", int'(irq), 1);
        chk("R4 hot period gap", last_gap, 5);

        // R7 enable gating and write-one clear
        wr('h08, 'h004 | 'h040 | 'h200);
        chk("R7 irq masked", int'(irq), 0);
        rd('h0C, v); chk("R7 pending kept while masked", v, 2);
        wr('h08, 'h006 | 'h040 | 'h200);
        code_a[1] = 3700;
        repeat (80) @(negedge clk);
        wr('h0C, 2);
        rd('h0C, v); chk("R7 pending cleared", v, 0);
        chk("R7 irq dropped", int'(irq), 0);
        repeat (80) @(negedge clk);
        chk("R4 back to normal period", last_gap, 21);

        // R8 shutdown on ch2 routed to GPIO, active low
        code_a[2] = 3400;
        repeat (100) @(negedge clk);
        chk("R8 gpio shutdown active low", int'(shut_gpio), 0);
        chk("R9 reset path idle", int'(shut_rst), 1);
        code_a[2] = 3700;
        repeat (100) @(negedge clk);
        chk("R8 latched after cooling", int'(shut_gpio), 0);
        wr('h04, 'h161);
        chk("R9 high polarity gpio", int'(shut_gpio), 1);
        chk("R9 high polarity reset idle", int'(shut_rst), 0);
        wr('h08, 'h006 | 'h040 | 'h600);
        chk("R9 reset routing", int'(shut_rst), 1);

        chk("R10 channel 0 never polled", int'(saw_rsvd), 0);
        wr('h04, 'h160);
        repeat (10) @(negedge clk);
        chk("R2 auto off idles request", int'(adc_start), 0);

        run = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule